// File: doc/BRIEF.md
# Iterative Day-of-Week Calculator

This unit takes a calendar date (year, month, day) and returns its day of the week. It uses no closed-form congruence. It starts from the first of January of the year 1000, a Wednesday, and steps forward through the calendar. Each clock it adds one whole year or one whole month to a running day count, and it keeps that count reduced modulo 7. The inputs are forced into range before the walk begins. Leap years follow the Gregorian rule throughout.

A caller presents a date and pulses `start`. The unit raises `busy` while it walks the calendar. It then pulses `done` for one cycle and holds the weekday on its output until the next accepted request. The run time grows with the distance from the epoch: one cycle per year plus one per month.

Top module: `weekday_calc`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `weekday` is 0.
- R2: Inputs are clamped before counting. A year below 1000 is treated as 1000. A month of 0 is treated as 1, and a month of 13 to 15 is treated as 12. A day of 0 is treated as 1.
- R3: A year is a leap year when it is divisible by 4 and either not divisible by 100 or divisible by 400. Only in a leap target year does February contribute 29 days. Every full year before the target year contributes 366 days if it is a leap year and 365 otherwise.
- R4: The date 1000-01-01 gives `weekday` = 3.
- R5: `weekday` equals (D + 3) mod 7, encoded 0 = Sunday through 6 = Saturday. D is the number of days from 1000-01-01 to the clamped date. For example, 2000-01-01 gives 6.
- R6: After `start` is accepted, `busy` stays high for exactly (Y − 999) + M consecutive cycles, where Y and M are the clamped year and month.
- R7: `done` is high for exactly one cycle, the cycle right after `busy` falls. `weekday` then holds its value until the next accepted `start`.
- R8: `start` is ignored while `busy` or `done` is high. Neither the result nor the run length changes, whatever the inputs carry at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| year_in | input | YEAR_W | Absolute year |
| month_in | input | 4 | Month, 1..12 |
| day_in | input | 5 | Day of month, 1..31 |
| busy | output | 1 | Calendar walk in progress |
| done | output | 1 | One-cycle result strobe |
| weekday | output | 3 | Day of week, 0 = Sunday |

## Verification
The bench builds the unit with its default parameters: a 12-bit year and the year-1000 Wednesday epoch. This makes every year up to 4095 reachable. That range covers the non-leap centuries 1700, 1800, 1900 and 2100, the 400-year leap years 1200, 1600 and 2000, and the longest walk, which ends at 4095-12. Random dates in 1000..2400, with out-of-range month and day codes mixed in, check the modulo-7 result and the run length against a reference count done in the bench. While runs are in flight, the bench also pulses `start` with unrelated inputs.

// File: rtl/weekday_calc.sv
module weekday_calc #(
  parameter int YEAR_W     = 12,
  parameter int EPOCH_YEAR = 1000,
  parameter int EPOCH_WDAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [YEAR_W-1:0] year_in,
  input  logic [3:0]        month_in,
  input  logic [4:0]        day_in,
  output logic              busy,
  output logic              done,
  output logic [2:0]        weekday
);

  localparam logic [YEAR_W-1:0] EPOCH  = YEAR_W'(EPOCH_YEAR);
  localparam logic [6:0]        C100_0 = 7'(EPOCH_YEAR % 100);
  localparam logic [8:0]        C400_0 = 9'(EPOCH_YEAR % 400);
  localparam logic [2:0]        WD0    = 3'(EPOCH_WDAY % 7);

  typedef enum logic [1:0] {S_IDLE, S_YEAR, S_MON, S_FIN} state_t;

  state_t            st;
  logic [YEAR_W-1:0] cur_y, tgt_y;
  logic [6:0]        c100;
  logic [8:0]        c400;
  logic [3:0]        cur_m, tgt_m;
  logic [4:0]        day_r;
  logic [2:0]        acc;
  logic              leap;
  logic [4:0]        dm1;
  logic [2:0]        dmod;

  function automatic logic [2:0] add7(input logic [2:0] a, input logic [2:0] b);
    logic [3:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s >= 4'd7) ? 3'(s - 4'd7) : s[2:0];
  endfunction

  function automatic logic [2:0] mlen7(input logic [3:0] m, input logic lp);
    if (m == 4'd2) return lp ? 3'd1 : 3'd0;
    if (m == 4'd4 || m == 4'd6 || m == 4'd9 || m == 4'd11) return 3'd2;
    return 3'd3;
  endfunction

  assign leap = (cur_y[1:0] == 2'b00) && (c100 != 7'd0 || c400 == 9'd0);
  assign dm1  = day_r - 5'd1;
  assign dmod = (dm1 >= 5'd28) ? 3'(dm1 - 5'd28) :
                (dm1 >= 5'd21) ? 3'(dm1 - 5'd21) :
                (dm1 >= 5'd14) ? 3'(dm1 - 5'd14) :
                (dm1 >= 5'd7)  ? 3'(dm1 - 5'd7)  : dm1[2:0];

  assign busy    = (st == S_YEAR) || (st == S_MON);
  assign done    = (st == S_FIN);
  assign weekday = acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cur_y <= '0;
      tgt_y <= '0;
      c100  <= '0;
      c400  <= '0;
      cur_m <= '0;
      tgt_m <= '0;
      day_r <= '0;
      acc   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          tgt_y <= (year_in < EPOCH) ? EPOCH : year_in;
          tgt_m <= (month_in == 4'd0) ? 4'd1 : (month_in > 4'd12) ? 4'd12 : month_in;
          day_r <= (day_in == 5'd0) ? 5'd1 : day_in;
          cur_y <= EPOCH;
          c100  <= C100_0;
          c400  <= C400_0;
          cur_m <= 4'd1;
          acc   <= WD0;
          st    <= S_YEAR;
        end
        S_YEAR: if (cur_y < tgt_y) begin
          acc   <= add7(acc, leap ? 3'd2 : 3'd1);
          cur_y <= cur_y + 1'b1;
          c100  <= (c100 == 7'd99)  ? 7'd0 : c100 + 7'd1;
          c400  <= (c400 == 9'd399) ? 9'd0 : c400 + 9'd1;
        end else begin
          st <= S_MON;
        end
        S_MON: if (cur_m < tgt_m) begin
          acc   <= add7(acc, mlen7(cur_m, leap));
          cur_m <= cur_m + 4'd1;
        end else begin
          acc <= add7(acc, dmod);
          st  <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module weekday_calc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [2:0] weekday
);
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n) done |-> weekday < 3'd7);
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r7_after_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy));
  a_r7_excl: assert property (@(posedge clk) disable iff (!rst_n) !(done && busy));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(weekday));
  a_r8_no_abort: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
endmodule

bind weekday_calc weekday_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .weekday(weekday)
);

// File: tb/weekday_calc_tb.sv
module weekday_calc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 190000;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [11:0] year_in = 0;
  logic [3:0]  month_in = 0;
  logic [4:0]  day_in = 0;
  logic        busy, done;
  logic [2:0]  weekday;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  weekday_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .year_in(year_in),
    .month_in(month_in), .day_in(day_in), .busy(busy), .done(done), .weekday(weekday)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_leap(int y);
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  function automatic int cy(int y);
    return (y < 1000) ? 1000 : y;
  endfunction

  function automatic int cm(int m);
    return (m < 1) ? 1 : (m > 12) ? 12 : m;
  endfunction

  function automatic int ref_wd(int yi, int mi, int di);
    int y, m, d, sum;
    int ml[12] = '{31,28,31,30,31,30,31,31,30,31,30,31};
    y = cy(yi); m = cm(mi); d = (di < 1) ? 1 : di;
    sum = 0;
    for (int k = 1000; k < y; k++) sum += 365 + (is_leap(k) ? 1 : 0);
    for (int k = 1; k < m; k++) sum += ml[k-1] + ((k == 2 && is_leap(y)) ? 1 : 0);
    sum += d - 1;
    return (sum + 3) % 7;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run(int y, int m, int d, bit noise, int exp_wd, string req);
    int n;
    @(negedge clk);
    year_in = 12'(y); month_in = 4'(m); day_in = 5'(d); start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (busy && cyc < MAX_CYC) begin
      n++;
      if (noise && (n % 5 == 1)) begin
        start = 1;
        year_in = 12'($urandom_range(0, 4095));
        month_in = 4'($urandom_range(0, 15));
        day_in = 5'($urandom_range(0, 31));
      end else start = 0;
      @(negedge clk);
    end
    start = 0;
    chk({req, "/R6 busy len"}, n, cy(y) - 999 + cm(m));
    chk({req, "/R7 done"}, int'(done), 1);
    chk(req, int'(weekday), exp_wd);
    @(negedge clk);
    chk({req, "/R7 done pulse"}, int'(done), 0);
    chk({req, "/R7 hold"}, int'(weekday), exp_wd);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc >= MAX_CYC) begin
        errors++;
        checks++;
        $display("FAIL watchdog R6: actual %0d expected <%0d", cyc, MAX_CYC);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 weekday", int'(weekday), 0);
    rst_n = 1;
    @(negedge clk);

    run(1000, 1, 1, 0, 3, "R4 epoch");
    run(2000, 1, 1, 0, 6, "R5 y2000");
    run(2024, 3, 1, 0, 5, "R5 2024-03-01");
    run(2000, 3, 1, 0, 3, "R3 2000 leap");
    run(1900, 3, 1, 0, ref_wd(1900, 3, 1), "R3 1900 common");
    run(1700, 3, 1, 0, ref_wd(1700, 3, 1), "R3 1700 common");
    run(1600, 3, 1, 0, ref_wd(1600, 3, 1), "R3 1600 leap");
    run(1200, 12, 31, 0, ref_wd(1200, 12, 31), "R3 1200 end");
    run(5, 1, 1, 0, 3, "R2 low year");
    run(1000, 0, 0, 0, 3, "R2 zero month day");
    run(1500, 15, 31, 0, ref_wd(1500, 12, 31), "R2 month 15");
    run(1500, 13, 0, 0, ref_wd(1500, 12, 1), "R2 month 13");
    run(4095, 12, 31, 0, ref_wd(4095, 12, 31), "R5 max year");
    run(1999, 6, 15, 1, ref_wd(1999, 6, 15), "R8 start ignored");

    for (int i = 0; i < 30; i++) begin
      int y, m, d;
      y = $urandom_range(900, 2400);
      m = $urandom_range(0, 15);
      d = $urandom_range(0, 31);
      run(y, m, d, (i % 3 == 0), ref_wd(y, m, d), "R5 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule